// File: doc/BRIEF.md
# Sprite Attribute Copy Engine

This block fills the 160-byte sprite attribute RAM from a 256-byte-aligned source page with no processor work. Software writes a page number to the trigger register. After a fixed start delay the engine reads the page byte by byte over the source bus and writes each byte into the attribute RAM at the same index. One byte moves every four cycles.

While bytes are moving, the engine takes over parts of the processor's view of memory. Attribute RAM accesses are blocked. Accesses to the bus that the copy occupies are bent toward the byte in flight: a read sees that byte, and a write lands in the attribute RAM in its place. The surrounding system drives the processor's access onto `cpu_*` and uses `cpu_ovr` to pick the engine's read data and to suppress the normal write. A new trigger during a copy abandons it and starts over. Page numbers in the top of the map are invalid sources and produce 0xFF bytes.

Top module: `attr_dma`

## Requirements
- R1: After reset, `busy`, `src_rd`, `ram_we` and `cpu_ovr` are low.
- R2: A trigger write stores `pg_wdata` as the source page. Byte k is fetched from address {page, k}, so `src_addr[15:8]` is the page and `src_addr[7:0]` is k, with k from 0 to 159.
- R3: With the trigger sampled at clock edge t, byte k is written to attribute index k at edge t+8+4k, with `ram_we` high for one cycle. The position counter starts at 0xFE and advances once per four cycles, so the first two steps write nothing.
- R4: Exactly 160 bytes are written. `busy` rises at the trigger edge and falls at the edge that writes index 159, after which the engine is idle.
- R5: A trigger during a copy discards the rest of that copy and restarts from index 0 with the new page, using the R3 timing counted from the new trigger.
- R6: While the copy window is open (from the write of index 0 until the write of index 159), an access to 0xFE00–0xFE9F asserts `cpu_ovr` with read data 0xFF, and a write there changes no attribute byte. Outside the window, and during the start delay, `cpu_ovr` stays low.
- R7: In the copy window, a read of a conflicting address asserts `cpu_ovr` and returns the most recent byte placed in the attribute RAM.
- R8: In the copy window, a write to a conflicting address asserts `cpu_ovr`. On the next edge the write data is stored in the attribute RAM at the current index. If that edge also advances the copy, the data goes to the new index in place of the fetched byte.
- R9: A page at or above 0xFE, or at or above 0xE0 when `enh_mode` is high, is invalid. For an invalid page no source read is issued, every written byte is 0xFF, and no address conflicts.
- R10: A source page in 0x80–0x9F conflicts only with 0x8000–0x9FFF. Any other valid page conflicts with every address below 0xFE00 outside 0x8000–0x9FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enh_mode | input | 1 | Enhanced mode; lowers the invalid-page limit to 0xE0 |
| pg_wr | input | 1 | Trigger register write strobe |
| pg_wdata | input | 8 | Source page number |
| src_rd | output | 1 | Source read strobe |
| src_addr | output | 16 | Source read address |
| src_rdata | input | 8 | Source read data, valid one cycle after `src_rd` |
| ram_we | output | 1 | Attribute RAM write enable |
| ram_addr | output | 8 | Attribute RAM write index |
| ram_wdata | output | 8 | Attribute RAM write data |
| cpu_req | input | 1 | Processor access valid |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | 16 | Processor access address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_ovr | output | 1 | Engine overrides this access |
| cpu_ovr_rdata | output | 8 | Read data to use when `cpu_ovr` is high |
| busy | output | 1 | Copy in progress |

## Verification
The checker holds on every cycle the properties that can be judged locally. Source strobes are single-cycle, carry an in-range index and never point at an invalid page. `busy` falls only together with the write of index 159, and there are no writes once the engine is idle. A redirected processor write lands on the next edge, and an overridden read returns either the last written byte or 0xFF. The exact 8+4k arrival schedule, the data fetched from each page, restart after a retrigger, and which address ranges conflict for each kind of page depend on whole scenarios, so only the bench's runs can show them.

// File: rtl/attr_dma_pkg.sv
package attr_dma_pkg;
  localparam int PAGE_W = 8;

  localparam logic [PAGE_W-1:0] VID_LO     = 8'h80;
  localparam logic [PAGE_W-1:0] VID_HI     = 8'h9F;
  localparam logic [PAGE_W-1:0] NORM_LIMIT = 8'hFE;
  localparam logic [PAGE_W-1:0] ENH_LIMIT  = 8'hE0;
  localparam logic [PAGE_W-1:0] ATTR_PAGE  = 8'hFE;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_MAIN  = 2'd1,
    SRC_VIDEO = 2'd2
  } src_cls_e;

  function automatic logic in_video(input logic [PAGE_W-1:0] pg);
    return (pg >= VID_LO) && (pg <= VID_HI);
  endfunction

  function automatic src_cls_e classify(input logic [PAGE_W-1:0] pg, input logic enh);
    if (pg >= (enh ? ENH_LIMIT : NORM_LIMIT)) return SRC_NONE;
    if (in_video(pg)) return SRC_VIDEO;
    return SRC_MAIN;
  endfunction
endpackage

// File: rtl/attr_dma_seq.sv
module attr_dma_seq #(
  parameter int XFER_LEN   = 160,
  parameter int STEP_CYC   = 4,
  parameter int LEAD_STEPS = 2,
  parameter int IDX_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  output logic             run_o,
  output logic [IDX_W-1:0] pos_o,
  output logic [IDX_W-1:0] nxt_pos_o,
  output logic             fetch_o,
  output logic             wr_byte_o,
  output logic             last_o,
  output logic             win_o
);
  localparam int PH_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [IDX_W-1:0] IDLE_POS = IDX_W'((2 ** IDX_W) - LEAD_STEPS);
  localparam logic [IDX_W:0]   LEN_X    = (IDX_W + 1)'(XFER_LEN);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(STEP_CYC - 1);
  localparam logic [PH_W-1:0]  PH_FETCH = PH_W'(STEP_CYC - 3);

  logic             run_q;
  logic [PH_W-1:0]  phase_q;
  logic [IDX_W-1:0] pos_q;
  logic [IDX_W-1:0] nxt;
  logic             step;
  logic             in_len;

  assign nxt       = pos_q + 1'b1;
  assign in_len    = {1'b0, nxt} < LEN_X;
  assign step      = run_q && (phase_q == PH_LAST) && !trig;
  assign wr_byte_o = step && in_len;
  assign last_o    = wr_byte_o && ({1'b0, nxt} == LEN_X - 1'b1);
  assign fetch_o   = run_q && (phase_q == PH_FETCH) && in_len && !trig;
  assign win_o     = run_q && ({1'b0, pos_q} < LEN_X);
  assign run_o     = run_q;
  assign pos_o     = pos_q;
  assign nxt_pos_o = nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      phase_q <= '0;
      pos_q   <= IDLE_POS;
    end else if (trig) begin
      run_q   <= 1'b1;
      phase_q <= '0;
      pos_q   <= IDLE_POS;
    end else if (run_q) begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
      if (step) begin
        if (last_o) begin
          run_q <= 1'b0;
          pos_q <= IDLE_POS;
        end else begin
          pos_q <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/attr_dma_src.sv
module attr_dma_src
  import attr_dma_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pg_wr,
  input  logic [PAGE_W-1:0]       pg_wdata,
  input  logic                    enh_mode,
  input  logic                    fetch,
  input  logic [IDX_W-1:0]        nxt_pos,
  input  logic [DATA_W-1:0]       src_rdata,
  output logic                    src_rd,
  output logic [PAGE_W+IDX_W-1:0] src_addr,
  output src_cls_e                cls_o,
  output logic [DATA_W-1:0]       fetched_o
);
  logic [PAGE_W-1:0] page_q;

  assign cls_o     = classify(page_q, enh_mode);
  assign fetched_o = (cls_o == SRC_NONE) ? FILL : src_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q   <= '0;
      src_rd   <= 1'b0;
      src_addr <= '0;
    end else begin
      if (pg_wr) page_q <= pg_wdata;
      src_rd <= fetch && (cls_o != SRC_NONE) && !pg_wr;
      if (fetch) src_addr <= {page_q, nxt_pos};
    end
  end
endmodule

// File: rtl/attr_dma_cpu.sv
module attr_dma_cpu
  import attr_dma_pkg::*;
#(
  parameter int XFER_LEN = 160,
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 8,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [PAGE_W+IDX_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  input  logic                    win,
  input  src_cls_e                cls,
  input  logic [IDX_W-1:0]        pos,
  input  logic [IDX_W-1:0]        nxt_pos,
  input  logic                    wr_byte,
  input  logic [DATA_W-1:0]       fetched,
  output logic                    cpu_ovr,
  output logic [DATA_W-1:0]       cpu_ovr_rdata,
  output logic                    ram_we,
  output logic [IDX_W-1:0]        ram_addr,
  output logic [DATA_W-1:0]       ram_wdata
);
  localparam logic [IDX_W:0] LEN_X = (IDX_W + 1)'(XFER_LEN);

  logic [PAGE_W-1:0] cpage;
  logic [IDX_W-1:0]  coff;
  logic              hit_attr;
  logic              hit_conf;
  logic              redirect;
  logic [DATA_W-1:0] cur_q;
  logic [DATA_W-1:0] wdata;

  assign cpage    = cpu_addr[PAGE_W+IDX_W-1 -: PAGE_W];
  assign coff     = cpu_addr[IDX_W-1:0];
  assign hit_attr = (cpage == ATTR_PAGE) && ({1'b0, coff} < LEN_X);

  always_comb begin
    unique case (cls)
      SRC_MAIN:  hit_conf = !in_video(cpage) && (cpage < ATTR_PAGE);
      SRC_VIDEO: hit_conf = in_video(cpage);
      default:   hit_conf = 1'b0;
    endcase
  end

  assign cpu_ovr       = cpu_req && win && (hit_attr || hit_conf);
  assign cpu_ovr_rdata = hit_attr ? FILL : cur_q;
  assign redirect      = cpu_req && cpu_we && win && hit_conf && !hit_attr;
  assign wdata         = redirect ? cpu_wdata : fetched;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      cur_q     <= FILL;
    end else begin
      ram_we <= wr_byte || redirect;
      if (wr_byte || redirect) begin
        ram_addr  <= wr_byte ? nxt_pos : pos;
        ram_wdata <= wdata;
        cur_q     <= wdata;
      end
    end
  end
endmodule

// File: rtl/attr_dma.sv
module attr_dma
  import attr_dma_pkg::*;
#(
  parameter int XFER_LEN   = 160,
  parameter int STEP_CYC   = 4,
  parameter int LEAD_STEPS = 2,
  parameter int IDX_W      = 8,
  parameter int DATA_W     = 8,
  parameter logic [DATA_W-1:0] FILL = '1,
  localparam int ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enh_mode,
  input  logic              pg_wr,
  input  logic [PAGE_W-1:0] pg_wdata,
  output logic              src_rd,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_rdata,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ovr,
  output logic [DATA_W-1:0] cpu_ovr_rdata,
  output logic              busy
);
  logic [IDX_W-1:0]  pos, nxt_pos;
  logic              fetch, wr_byte, last, win;
  src_cls_e          cls;
  logic [DATA_W-1:0] fetched;

  attr_dma_seq #(
    .XFER_LEN(XFER_LEN), .STEP_CYC(STEP_CYC),
    .LEAD_STEPS(LEAD_STEPS), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .trig(pg_wr),
    .run_o(busy), .pos_o(pos), .nxt_pos_o(nxt_pos),
    .fetch_o(fetch), .wr_byte_o(wr_byte), .last_o(last), .win_o(win)
  );

  attr_dma_src #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .FILL(FILL)
  ) u_src (
    .clk(clk), .rst(rst), .pg_wr(pg_wr), .pg_wdata(pg_wdata),
    .enh_mode(enh_mode), .fetch(fetch), .nxt_pos(nxt_pos),
    .src_rdata(src_rdata), .src_rd(src_rd), .src_addr(src_addr),
    .cls_o(cls), .fetched_o(fetched)
  );

  attr_dma_cpu #(
    .XFER_LEN(XFER_LEN), .IDX_W(IDX_W), .DATA_W(DATA_W), .FILL(FILL)
  ) u_cpu (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .win(win), .cls(cls),
    .pos(pos), .nxt_pos(nxt_pos), .wr_byte(wr_byte), .fetched(fetched),
    .cpu_ovr(cpu_ovr), .cpu_ovr_rdata(cpu_ovr_rdata),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  logic unused_last;
  assign unused_last = last;
endmodule

// File: rtl/attr_dma_chk.sv
module attr_dma_chk #(
  parameter int XFER_LEN = 160,
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enh_mode,
  input logic              src_rd,
  input logic [ADDR_W-1:0] src_addr,
  input logic              ram_we,
  input logic [IDX_W-1:0]  ram_addr,
  input logic [DATA_W-1:0] ram_wdata,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_ovr,
  input logic [DATA_W-1:0] cpu_ovr_rdata,
  input logic              busy
);
  logic [DATA_W-1:0] last_w;
  logic              attr_pg;

  assign attr_pg = (cpu_addr[ADDR_W-1:IDX_W] == 8'hFE);

  always_ff @(posedge clk) begin
    if (rst) last_w <= '1;
    else if (ram_we) last_w <= ram_wdata;
  end

  AST_SRC_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    src_rd |=> !src_rd); // R3
  AST_SRC_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    src_rd |-> (src_addr[IDX_W-1:0] < IDX_W'(XFER_LEN))); // R2
  AST_SRC_VALID_PAGE: assert property (@(posedge clk) disable iff (rst)
    src_rd |-> (enh_mode ? (src_addr[ADDR_W-1:IDX_W] < 8'hE0)
                         : (src_addr[ADDR_W-1:IDX_W] < 8'hFE))); // R9
  AST_LAST_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (ram_we && (ram_addr == IDX_W'(XFER_LEN - 1)))); // R4
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !ram_we); // R4
  AST_OVR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    cpu_ovr |-> busy); // R6
  AST_ATTR_READ_FILL: assert property (@(posedge clk) disable iff (rst)
    (cpu_ovr && attr_pg) |-> (cpu_ovr_rdata == '1)); // R6
  AST_CONF_READ: assert property (@(posedge clk) disable iff (rst)
    (cpu_ovr && !attr_pg) |-> (cpu_ovr_rdata == (ram_we ? ram_wdata : last_w))); // R7
  AST_REDIRECT_DATA: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_we && cpu_ovr && !attr_pg) |=>
      (ram_we && (ram_wdata == $past(cpu_wdata)))); // R8
endmodule

bind attr_dma attr_dma_chk u_chk (
  .clk(clk), .rst(rst), .enh_mode(enh_mode), .src_rd(src_rd),
  .src_addr(src_addr), .ram_we(ram_we), .ram_addr(ram_addr),
  .ram_wdata(ram_wdata), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ovr(cpu_ovr),
  .cpu_ovr_rdata(cpu_ovr_rdata), .busy(busy)
);

// File: tb/sim_attr_dma.sv
`timescale 1ns/1ps
module sim_attr_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enh_mode = 1'b0;
  logic        pg_wr = 1'b0;
  logic [7:0]  pg_wdata = '0;
  logic        src_rd;
  logic [15:0] src_addr;
  logic [7:0]  src_rdata = '0;
  logic        ram_we;
  logic [7:0]  ram_addr;
  logic [7:0]  ram_wdata;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ovr;
  logic [7:0]  cpu_ovr_rdata;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  attr_dma u0 (
    .clk(clk), .rst(rst), .enh_mode(enh_mode), .pg_wr(pg_wr), .pg_wdata(pg_wdata),
    .src_rd(src_rd), .src_addr(src_addr), .src_rdata(src_rdata),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ovr(cpu_ovr), .cpu_ovr_rdata(cpu_ovr_rdata), .busy(busy)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // source memory: one-cycle read latency
  always @(posedge clk) if (src_rd) src_rdata <= mem_f(src_addr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start(input logic [7:0] pg);
    pg_wr = 1'b1; pg_wdata = pg;
    @(posedge clk);
    @(negedge clk);
    pg_wr = 1'b0;
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // walks one full copy; called at sample 0 after the trigger edge
  task automatic check_copy(input logic [7:0] pg, input bit valid);
    int wcount = 0, rcount = 0, bad_w = 0, bad_busy = 0, bad_src = 0;
    for (int m = 0; m < 660; m++) begin
      if (ram_we) begin
        if (!(wcount < 160 && m == 8 + 4 * wcount && ram_addr == 8'(wcount) &&
              ram_wdata == (valid ? mem_f({pg, 8'(wcount)}) : 8'hFF))) bad_w++;
        wcount++;
      end
      if (src_rd) begin
        if (src_addr != {pg, 8'(rcount)}) bad_src++;
        rcount++;
      end
      if (busy != (m < 644)) bad_busy++;
      @(negedge clk);
    end
    check(bad_w == 0 && wcount == 160, "R3 write schedule/index/data", bad_w, 0);
    check(bad_busy == 0, "R4 busy window", bad_busy, 0);
    if (valid) check(bad_src == 0 && rcount == 160, "R2 source addresses", rcount, 160);
    else       check(rcount == 0, "R9 no source reads on invalid page", rcount, 0);
  endtask

  // vector: [9]=enh_mode, [8:1]=page, [0]=page expected valid
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 8'h00, 1'b1}, {1'b0, 8'hC3, 1'b1}, {1'b0, 8'hFD, 1'b1},
    {1'b0, 8'hFE, 1'b0}, {1'b0, 8'hFF, 1'b0}, {1'b1, 8'hDF, 1'b1},
    {1'b1, 8'hE0, 1'b0}, {1'b0, 8'hE0, 1'b1}
  };

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    skip(3);
    rst = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 16'hFE00; #0.5;
    check(!busy && !src_rd && !ram_we && !cpu_ovr, "R1 reset state",
          {busy, src_rd, ram_we, cpu_ovr}, 0);
    cpu_req = 1'b0;

    foreach (VEC[i]) begin
      enh_mode = VEC[i][9];
      start(VEC[i][8:1]);
      check_copy(VEC[i][8:1], VEC[i][0]);
    end
    enh_mode = 1'b0;

    // R5: retrigger mid-copy restarts with the new page
    start(8'h20);
    skip(100);
    start(8'h40);
    check_copy(8'h40, 1'b1);

    // conflict behaviour, main-bus page
    start(8'h12);
    skip(3);
    cpu_req = 1'b1; cpu_addr = 16'hC000; #0.5;
    check(!cpu_ovr, "R6 no override during start delay", cpu_ovr, 0);
    cpu_req = 1'b0;
    skip(26);  // sample 29: index 5 holds
    cpu_req = 1'b1; cpu_addr = 16'hC123; #0.5;
    check(cpu_ovr && cpu_ovr_rdata == mem_f(16'h1205), "R7 conflict read", cpu_ovr_rdata, mem_f(16'h1205));
    cpu_addr = 16'hFE10; #0.5;
    check(cpu_ovr && cpu_ovr_rdata == 8'hFF, "R6 attribute read blocked", cpu_ovr_rdata, 8'hFF);
    cpu_addr = 16'h8100; #0.5;
    check(!cpu_ovr, "R10 video bus free for main page", cpu_ovr, 0);
    cpu_we = 1'b1; cpu_addr = 16'hC000; cpu_wdata = 8'hA5; #0.2;
    check(cpu_ovr, "R8 conflict write overridden", cpu_ovr, 1);
    @(negedge clk);  // sample 30
    check(ram_we && ram_addr == 8'd5 && ram_wdata == 8'hA5, "R8 redirected write",
          {ram_we, ram_addr, ram_wdata}, {1'b1, 8'd5, 8'hA5});
    cpu_we = 1'b0; cpu_addr = 16'hC123; #0.5;
    check(cpu_ovr_rdata == 8'hA5, "R7 read sees redirected byte", cpu_ovr_rdata, 8'hA5);
    cpu_we = 1'b1; cpu_addr = 16'hFE03; cpu_wdata = 8'h3C;
    @(negedge clk);  // sample 31
    check(!ram_we, "R6 attribute write ignored", ram_we, 0);
    cpu_req = 1'b0; cpu_we = 1'b0;
    while (busy) @(negedge clk);
    skip(2);
    cpu_req = 1'b1; cpu_addr = 16'hC000; #0.5;
    check(!cpu_ovr, "R6 no override when idle", cpu_ovr, 0);
    cpu_req = 1'b0;

    // video-bus page
    start(8'h85);
    skip(29);
    cpu_req = 1'b1; cpu_addr = 16'h9000; #0.5;
    check(cpu_ovr && cpu_ovr_rdata == mem_f(16'h8505), "R10 video page conflict", cpu_ovr_rdata, mem_f(16'h8505));
    cpu_addr = 16'hC000; #0.5;
    check(!cpu_ovr, "R10 main bus free for video page", cpu_ovr, 0);
    cpu_req = 1'b0;
    while (busy) @(negedge clk);

    // invalid page: no conflicts, attribute RAM still blocked
    start(8'hFE);
    skip(29);
    cpu_req = 1'b1; cpu_addr = 16'h1234; #0.5;
    check(!cpu_ovr, "R9 invalid page has no conflict", cpu_ovr, 0);
    cpu_addr = 16'hFE00; #0.5;
    check(cpu_ovr && cpu_ovr_rdata == 8'hFF, "R6 attribute blocked on invalid page", cpu_ovr_rdata, 8'hFF);
    cpu_req = 1'b0;
    while (busy) @(negedge clk);
    skip(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule